// File: doc/BRIEF.md
# Programmable Period Down Counter

This block is a small down counter, seven bits wide by default, that divides its clock by a programmable period. A register bit written from the bus acts as the master start. A hardware enable input and a hardware load input can each be present or absent, chosen when the block is built. When an input is absent, its value is fixed inside the block.

Once started, the counter first takes the period value. It then steps down by one on every enabled clock. After it passes through zero it reloads the period, so one full cycle lasts period+1 enabled clocks. A registered terminal-count output pulses on the clock that follows an enabled clock spent at zero. A hardware load restarts the count from the period, but only while the counter is enabled. A load that arrives at zero also cancels the terminal-count pulse that would otherwise follow.

Top module: `period_countdown`

## Requirements
- R1: On an enabled clock with the count at 0 and no load, the count takes period_i. A full cycle therefore visits period_i, period_i-1, ..., 0, which is period_i+1 enabled clocks.
- R2: After reset the start bit is 0 and the count holds. A clock with start_wr_i=1 stores start_wdata_i into the start bit. Counting begins only after a 1 has been stored, and it stops again once a 0 is stored.
- R3: The first enabled clock after the start bit becomes 1 loads period_i, even when the count is 0, and raises no terminal count. Each later enabled clock without a load decrements a nonzero count by one.
- R4: tc_o is registered. It is 1 exactly on the cycle after an enabled clock where the count was 0 with no load and no pending first-clock load.
- R5: The count changes only on clocks where the start bit and the effective hardware enable are both 1. On any other clock it holds its value.
- R6: With hw_ld_i=1 on an enabled clock, the count takes period_i. With hw_ld_i=1 while not enabled, the count is left unchanged.
- R7: A load on an enabled clock where the count is 0 keeps tc_o at 0 on the next cycle.
- R8: With USE_HW_EN=0 the enable is taken as 1 whatever hw_en_i is. With USE_HW_LD=0 the load is taken as 0 whatever hw_ld_i is.
- R9: For period_i of 1 or more, tc_o is high for a single cycle per pass through zero. It stays 0 while the counter is held or stopped, including a hold at zero.
- R10: Asserting rst_n low sets count_o to INIT_VAL, tc_o to 0 and the start bit to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_wr_i | input | 1 | Bus write strobe for the start bit |
| start_wdata_i | input | 1 | Value written to the start bit |
| period_i | input | WIDTH | Reload value |
| hw_en_i | input | 1 | Hardware enable (used when USE_HW_EN=1) |
| hw_ld_i | input | 1 | Hardware load (used when USE_HW_LD=1) |
| count_o | output | WIDTH | Current count |
| tc_o | output | 1 | Registered terminal-count pulse |

## Verification
The hardest condition to reach is a load at the exact clock the count sits at zero. That clock is also where the terminal count would otherwise be armed. The stimulus table times hw_ld_i onto that clock, and it also holds the count at zero with the enable low to show that no pulse escapes. A second hard case is restarting while the count is already zero. The bench stops the counter at zero and then writes the start bit again, which checks that the first-clock load wins over the terminal count. A second instance built with both inputs unrouted receives opposing fixed levels to show that they are ignored.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  localparam int unsigned CNT_W = 7;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_LOAD = 2'd1,
    ACT_DEC  = 2'd2
  } cnt_act_e;
endpackage

// File: rtl/pcd_ctrl.sv
module pcd_ctrl
  import pcd_pkg::*;
#(
  parameter bit USE_HW_EN = 1'b1,
  parameter bit USE_HW_LD = 1'b1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start_wr_i,
  input  logic     start_wdata_i,
  input  logic     hw_en_i,
  input  logic     hw_ld_i,
  input  logic     cnt_zero_i,
  output cnt_act_e act_o,
  output logic     tc_set_o,
  output logic     en_eff_o,
  output logic     ld_eff_o,
  output logic     start_q_o,
  output logic     primed_q_o
);
  logic start_q, start_d;
  logic primed_q, primed_d;
  logic en_hw, ld_hw;

  generate
    if (USE_HW_EN) begin : g_en_routed
      assign en_hw = hw_en_i;
    end else begin : g_en_fixed
      logic unused_en;
      assign unused_en = hw_en_i;
      assign en_hw = 1'b1;
    end
    if (USE_HW_LD) begin : g_ld_routed
      assign ld_hw = hw_ld_i;
    end else begin : g_ld_fixed
      logic unused_ld;
      assign unused_ld = hw_ld_i;
      assign ld_hw = 1'b0;
    end
  endgenerate

  assign en_eff_o = start_q & en_hw;
  assign ld_eff_o = ld_hw;

  // next-state logic
  always_comb begin
    start_d  = start_wr_i ? start_wdata_i : start_q;
    primed_d = primed_q;
    if (!start_q)      primed_d = 1'b0;
    else if (en_eff_o) primed_d = 1'b1;
  end

  always_comb begin
    act_o = ACT_HOLD;
    if (en_eff_o) begin
      if (!primed_q || ld_hw || cnt_zero_i) act_o = ACT_LOAD;
      else                                  act_o = ACT_DEC;
    end
  end

  assign tc_set_o = en_eff_o & primed_q & cnt_zero_i & ~ld_hw;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q  <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      start_q  <= start_d;
      primed_q <= primed_d;
    end
  end

  assign start_q_o  = start_q;
  assign primed_q_o = primed_q;
endmodule

// File: rtl/pcd_count.sv
module pcd_count
  import pcd_pkg::*;
#(
  parameter int unsigned WIDTH    = CNT_W,
  parameter int unsigned INIT_VAL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cnt_act_e         act_i,
  input  logic [WIDTH-1:0] period_i,
  output logic [WIDTH-1:0] count_o,
  output logic             zero_o
);
  localparam logic [WIDTH-1:0] INIT_CNT = WIDTH'(INIT_VAL);

  logic [WIDTH-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = (act_i != ACT_HOLD);

  always_comb begin
    unique case (act_i)
      ACT_LOAD: cnt_d = period_i;
      ACT_DEC:  cnt_d = cnt_q - 1'b1;
      default:  cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= INIT_CNT;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
  assign zero_o  = (cnt_q == '0);
endmodule

// File: rtl/pcd_tc.sv
module pcd_tc (
  input  logic clk,
  input  logic rst_n,
  input  logic tc_set_i,
  output logic tc_o
);
  logic tc_q, tc_d;

  assign tc_d = tc_set_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tc_q <= 1'b0;
    else        tc_q <= tc_d;
  end

  assign tc_o = tc_q;
endmodule

// File: rtl/period_countdown.sv
module period_countdown
  import pcd_pkg::*;
#(
  parameter int unsigned WIDTH     = CNT_W,
  parameter int unsigned INIT_VAL  = 0,
  parameter bit          USE_HW_EN = 1'b1,
  parameter bit          USE_HW_LD = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_wr_i,
  input  logic             start_wdata_i,
  input  logic [WIDTH-1:0] period_i,
  input  logic             hw_en_i,
  input  logic             hw_ld_i,
  output logic [WIDTH-1:0] count_o,
  output logic             tc_o
);
  cnt_act_e act;
  logic     cnt_zero, tc_set;
  logic     en_eff, ld_eff, start_q, primed_q;

  pcd_ctrl #(.USE_HW_EN(USE_HW_EN), .USE_HW_LD(USE_HW_LD)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_wr_i   (start_wr_i),
    .start_wdata_i(start_wdata_i),
    .hw_en_i      (hw_en_i),
    .hw_ld_i      (hw_ld_i),
    .cnt_zero_i   (cnt_zero),
    .act_o        (act),
    .tc_set_o     (tc_set),
    .en_eff_o     (en_eff),
    .ld_eff_o     (ld_eff),
    .start_q_o    (start_q),
    .primed_q_o   (primed_q)
  );

  pcd_count #(.WIDTH(WIDTH), .INIT_VAL(INIT_VAL)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .act_i   (act),
    .period_i(period_i),
    .count_o (count_o),
    .zero_o  (cnt_zero)
  );

  pcd_tc u_tc (
    .clk     (clk),
    .rst_n   (rst_n),
    .tc_set_i(tc_set),
    .tc_o    (tc_o)
  );
endmodule

// File: rtl/pcd_checker.sv
module pcd_checker #(
  parameter int unsigned WIDTH     = 7,
  parameter bit          USE_HW_EN = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] count_o,
  input logic             tc_o,
  input logic [WIDTH-1:0] period_i,
  input logic             hw_en_i,
  input logic             en_eff,
  input logic             ld_eff,
  input logic             start_q,
  input logic             primed_q
);
  AST_RELOAD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (en_eff && primed_q && !ld_eff && count_o == '0) |=> (count_o == $past(period_i))); // R1

  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_q) |=> $stable(count_o)); // R2

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (en_eff && primed_q && !ld_eff && count_o != '0) |=> (count_o == $past(count_o) - 1'b1)); // R3

  AST_TC_FOLLOWS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    tc_o |-> ($past(count_o) == '0)); // R4

  AST_HOLD_NO_HW_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (USE_HW_EN && !hw_en_i) |=> $stable(count_o)); // R5

  AST_LOAD_TAKES_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (en_eff && ld_eff) |=> (count_o == $past(period_i))); // R6

  AST_LOAD_ZERO_NO_TC: assert property (@(posedge clk) disable iff (!rst_n)
    (en_eff && ld_eff && count_o == '0) |=> !tc_o); // R7

  AST_TC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_o && count_o != '0) |=> !tc_o); // R9
endmodule

bind period_countdown pcd_checker #(.WIDTH(WIDTH), .USE_HW_EN(USE_HW_EN)) u_pcd_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .count_o (count_o),
  .tc_o    (tc_o),
  .period_i(period_i),
  .hw_en_i (hw_en_i),
  .en_eff  (en_eff),
  .ld_eff  (ld_eff),
  .start_q (start_q),
  .primed_q(primed_q)
);

// File: tb/tb_period_countdown.sv
`timescale 1ns/1ps
module tb_period_countdown;
  localparam int W = 7;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         we, wv, en, ld;
  logic [W-1:0] per;
  logic [W-1:0] cnt, cnt_fix;
  logic         tc, tc_fix;
  int           errors = 0;
  int           checks = 0;

  always #2 clk = ~clk;

  period_countdown #(.WIDTH(W), .INIT_VAL(5), .USE_HW_EN(1'b1), .USE_HW_LD(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .start_wr_i(we), .start_wdata_i(wv), .period_i(per),
    .hw_en_i(en), .hw_ld_i(ld), .count_o(cnt), .tc_o(tc));

  // unrouted variant: inputs tied to levels opposite to their forced values
  period_countdown #(.WIDTH(W), .INIT_VAL(0), .USE_HW_EN(1'b0), .USE_HW_LD(1'b0)) dut_fix (
    .clk(clk), .rst_n(rst_n), .start_wr_i(we), .start_wdata_i(wv), .period_i(per),
    .hw_en_i(1'b0), .hw_ld_i(1'b1), .count_o(cnt_fix), .tc_o(tc_fix));

  // {we, wdata, hw_en, hw_ld, period, expected count, expected tc}
  localparam int NV = 32;
  localparam logic [18:0] VEC [NV] = '{
    {1'b0,1'b0,1'b1,1'b0,7'd3,7'd5,1'b0}, // R2 not started
    {1'b1,1'b1,1'b1,1'b0,7'd3,7'd5,1'b0}, // R2 write start
    {1'b0,1'b0,1'b1,1'b0,7'd3,7'd3,1'b0}, // R3 first load
    {1'b0,1'b0,1'b1,1'b0,7'd3,7'd2,1'b0}, // R3
    {1'b0,1'b0,1'b1,1'b0,7'd3,7'd1,1'b0},
    {1'b0,1'b0,1'b1,1'b0,7'd3,7'd0,1'b0},
    {1'b0,1'b0,1'b1,1'b0,7'd3,7'd3,1'b1}, // R1 R4
    {1'b0,1'b0,1'b1,1'b0,7'd3,7'd2,1'b0}, // R9
    {1'b0,1'b0,1'b0,1'b0,7'd3,7'd2,1'b0}, // R5 hold
    {1'b0,1'b0,1'b0,1'b1,7'd3,7'd2,1'b0}, // R6 load ignored
    {1'b0,1'b0,1'b1,1'b1,7'd3,7'd3,1'b0}, // R6 load
    {1'b0,1'b0,1'b1,1'b0,7'd3,7'd2,1'b0},
    {1'b0,1'b0,1'b1,1'b0,7'd3,7'd1,1'b0},
    {1'b0,1'b0,1'b1,1'b0,7'd3,7'd0,1'b0},
    {1'b0,1'b0,1'b1,1'b1,7'd3,7'd3,1'b0}, // R7 load at zero
    {1'b0,1'b0,1'b1,1'b0,7'd3,7'd2,1'b0}, // R7
    {1'b0,1'b0,1'b1,1'b0,7'd3,7'd1,1'b0},
    {1'b0,1'b0,1'b1,1'b0,7'd3,7'd0,1'b0},
    {1'b0,1'b0,1'b0,1'b0,7'd3,7'd0,1'b0}, // R9 hold at zero
    {1'b0,1'b0,1'b1,1'b0,7'd3,7'd3,1'b1}, // R4
    {1'b0,1'b0,1'b1,1'b0,7'd1,7'd2,1'b0}, // R1 new period at reload only
    {1'b0,1'b0,1'b1,1'b0,7'd1,7'd1,1'b0},
    {1'b0,1'b0,1'b1,1'b0,7'd1,7'd0,1'b0},
    {1'b0,1'b0,1'b1,1'b0,7'd1,7'd1,1'b1}, // R1
    {1'b0,1'b0,1'b1,1'b0,7'd1,7'd0,1'b0},
    {1'b0,1'b0,1'b1,1'b0,7'd1,7'd1,1'b1},
    {1'b1,1'b0,1'b1,1'b0,7'd1,7'd0,1'b0}, // R2 write stop
    {1'b0,1'b0,1'b1,1'b0,7'd1,7'd0,1'b0}, // R2 stopped
    {1'b1,1'b1,1'b1,1'b0,7'd1,7'd0,1'b0}, // R2 restart
    {1'b0,1'b0,1'b1,1'b0,7'd1,7'd1,1'b0}, // R3 load at zero without tc
    {1'b0,1'b0,1'b1,1'b0,7'd1,7'd0,1'b0},
    {1'b0,1'b0,1'b1,1'b0,7'd1,7'd1,1'b1}
  };

  task automatic chk(input string req, input logic [W-1:0] act_c, input logic act_t,
                     input logic [W-1:0] exp_c, input logic exp_t);
    checks++;
    if (act_c !== exp_c || act_t !== exp_t) begin
      errors++;
      $display("FAIL %s: count=%0d tc=%0b expected count=%0d tc=%0b", req, act_c, act_t, exp_c, exp_t);
    end
  endtask

  task automatic step(input logic w, input logic v, input logic e, input logic l, input logic [W-1:0] p);
    we = w; wv = v; en = e; ld = l; per = p;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; we = 0; wv = 0; en = 0; ld = 0; per = 7'd3;
    repeat (3) @(negedge clk);
    chk("R10 reset", cnt, tc, 7'd5, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][18], VEC[i][17], VEC[i][16], VEC[i][15], VEC[i][14:8]);
      chk($sformatf("vector %0d (R1..R9 table)", i), cnt, tc, VEC[i][7:1], VEC[i][0]);
    end
    // R10: reset in mid-run restores initial value and clears start
    step(0, 0, 1, 0, 7'd2);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 mid-run reset", cnt, tc, 7'd5, 1'b0);
    chk("R10 fixed-variant reset", cnt_fix, tc_fix, 7'd0, 1'b0);
    rst_n = 1'b1;
    step(0, 0, 1, 0, 7'd2);
    chk("R10 start cleared by reset", cnt, tc, 7'd5, 1'b0);
    // R8: unrouted variant counts although hw_en is 0 and ignores hw_ld=1
    step(1, 1, 1, 0, 7'd2);
    chk("R8 start write", cnt_fix, tc_fix, 7'd0, 1'b0);
    step(0, 0, 1, 0, 7'd2);
    chk("R8 first load", cnt_fix, tc_fix, 7'd2, 1'b0);
    step(0, 0, 1, 0, 7'd2);
    chk("R8 enable forced", cnt_fix, tc_fix, 7'd1, 1'b0);
    step(0, 0, 1, 0, 7'd2);
    chk("R8 load forced off", cnt_fix, tc_fix, 7'd0, 1'b0);
    step(0, 0, 1, 0, 7'd2);
    chk("R8 tc reached", cnt_fix, tc_fix, 7'd2, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #20000;
    errors++; checks++;
    $display("FAIL watchdog: count=%0d tc=%0b expected completion", cnt, tc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule